// File: doc/BRIEF.md
# Hardware Address Breakpoint Unit

This block watches a simple pipeline's instruction fetches and data accesses and raises a debug trap when one of four programmable breakpoint slots matches. Each slot holds an address and a control field that sets the access kind (execute, write only, read or write, or an I/O kind that never fires) and the length of the watched range. Hits are recorded in sticky status bits that software clears by writing the status register. A trap flag makes the unit raise a single-step trap each time an instruction completes. A resume flag hides instruction-breakpoint hits until the next instruction completes, so a handler can return to a breakpointed instruction without trapping on it again.

Software reaches the slot addresses, the control word, the status word and the flags word through a one-cycle register write port and a combinational read port. The pipeline drives fetch addresses, data accesses and an instruction-complete strobe. It receives the trap outputs in the same cycle, so an instruction-breakpoint trap is seen before the instruction executes.

Top module: `hw_brk_unit`

## Requirements
- R1: After reset every register reads zero (addresses, control, status, flags), and no trap output is high.
- R2: Register select 0 to 3 picks the address of slot 0 to 3, 4 the control word, 5 the status word and 6 the flags word. A write takes effect at the clock edge. The read data shows the selected register combinationally.
- R3: Control layout for slot i: the enable is bit 2i, the kind is bits 16+4i..17+4i and the length is bits 18+4i..19+4i. Other bits read zero. A write that gives a slot kind 00 stores that slot's length as 00.
- R4: A fetch raises bp_trap in the same cycle when an enabled slot of kind 00 holds exactly the fetch address.
- R5: A data access of size code s (2^s bytes, aligned to its size) matches an enabled data slot when its byte range overlaps [address, address+L). L is 1, 2, 4 or 8 bytes for length codes 00, 01, 11 and 10, and the slot address is taken as aligned to L.
- R6: Kind 01 matches writes only and kind 11 matches reads and writes. Kind 10 never matches a fetch or a data access.
- R7: Clearing a slot's enable stops its matches and leaves its address, kind and length readable unchanged.
- R8: When several slots match in one cycle, all of their status bits (bits 0 to 3) are set. bp_slot gives the lowest-numbered matching slot.
- R9: Status bits stay set until software writes the status word. A write replaces bits 0 to 3 and 14, and all other status bits read zero. A hit in the same cycle as the write is still recorded.
- R10: While the resume flag (flags bit 16) is set, fetch matches are ignored. Data matches are not affected. The flag clears at the first instruction-complete strobe.
- R11: While the trap flag (flags bit 8) is set, each instruction-complete strobe raises step_trap in that cycle and sets status bit 14 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| fetch_valid | input | 1 | Instruction fetch present |
| fetch_addr | input | AW | Fetch address |
| insn_done | input | 1 | An instruction completed this cycle |
| data_valid | input | 1 | Data access present |
| data_write | input | 1 | Data access is a write |
| data_addr | input | AW | Data access address |
| data_size | input | 2 | Access size code, 2^code bytes |
| bp_trap | output | 1 | A breakpoint slot matched |
| bp_slot | output | 2 | Lowest matching slot |
| step_trap | output | 1 | Single-step trap |

## Verification
The bench sweeps every length code against every access size and every aligned offset around a slot. A compare that kept too many low address bits would miss partial overlaps, and a decode that treated the length code as monotonic would watch 4 bytes where 8 were asked for. It checks that the resume flag hides fetch hits but not data hits, and that the flag stays set until an instruction completes. A design that cleared it on the next cycle, or also masked data hits, would fail here. It also sets two slots on one address to check lowest-slot priority and that both status bits are recorded. Finally it checks that disabled slots and I/O-kind slots stay silent while their fields read back unchanged.

// File: rtl/hw_brk_unit.sv
module hw_brk_unit #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          insn_done,
  input  logic          data_valid,
  input  logic          data_write,
  input  logic [AW-1:0] data_addr,
  input  logic [1:0]    data_size,
  output logic          bp_trap,
  output logic [1:0]    bp_slot,
  output logic          step_trap
);
  localparam int NS = 4;

  logic [AW-1:0] addr_q [NS];
  logic [31:0]   ctrl_q;
  logic [31:0]   ctrl_fix;
  logic [4:0]    stat_q;
  logic          tf_q, rf_q;
  logic [NS-1:0] ihit, dhit, hit, io_kind;

  wire wr_ctrl  = reg_wr && reg_sel == 3'd4;
  wire wr_stat  = reg_wr && reg_sel == 3'd5;
  wire wr_flags = reg_wr && reg_sel == 3'd6;

  function automatic logic [1:0] len_log(input logic [1:0] code);
    case (code)
      2'b00:   len_log = 2'd0;
      2'b01:   len_log = 2'd1;
      2'b11:   len_log = 2'd2;
      default: len_log = 2'd3;
    endcase
  endfunction

  always_comb begin
    ctrl_fix = reg_wdata & 32'hFFFF_0055;
    for (int i = 0; i < NS; i++)
      if (reg_wdata[16+4*i +: 2] == 2'b00) ctrl_fix[18+4*i +: 2] = 2'b00;
  end

  for (genvar i = 0; i < NS; i++) begin : g_slot
    wire          en   = ctrl_q[2*i];
    wire [1:0]    kind = ctrl_q[16+4*i +: 2];
    wire [1:0]    lcod = ctrl_q[18+4*i +: 2];
    wire [1:0]    sh   = (len_log(lcod) > data_size) ? len_log(lcod) : data_size;
    wire [AW-1:0] msk  = {AW{1'b1}} << sh;

    assign ihit[i]    = fetch_valid && en && kind == 2'b00 && !rf_q && fetch_addr == addr_q[i];
    assign dhit[i]    = data_valid && en && (kind == 2'b11 || (kind == 2'b01 && data_write))
                        && ((data_addr ^ addr_q[i]) & msk) == '0;
    assign io_kind[i] = kind == 2'b10;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) addr_q[i] <= '0;
      else if (reg_wr && reg_sel == 3'(i)) addr_q[i] <= reg_wdata[AW-1:0];

    AST_INSN_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      kind == 2'b00 |-> lcod == 2'b00); // R3
  end

  assign hit       = ihit | dhit;
  assign bp_trap   = |hit;
  assign bp_slot   = hit[0] ? 2'd0 : hit[1] ? 2'd1 : hit[2] ? 2'd2 : hit[3] ? 2'd3 : 2'd0;
  assign step_trap = insn_done && tf_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_fix;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stat_q <= '0;
    else stat_q <= (wr_stat ? {reg_wdata[14], reg_wdata[3:0]} : stat_q) | {step_trap, hit};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tf_q <= 1'b0;
      rf_q <= 1'b0;
    end else if (wr_flags) begin
      tf_q <= reg_wdata[8];
      rf_q <= reg_wdata[16];
    end else if (insn_done) begin
      rf_q <= 1'b0;
    end

  always_comb
    case (reg_sel)
      3'd0, 3'd1, 3'd2, 3'd3: reg_rdata = 32'(addr_q[reg_sel[1:0]]);
      3'd4:    reg_rdata = ctrl_q;
      3'd5:    reg_rdata = {17'b0, stat_q[4], 10'b0, stat_q[3:0]};
      3'd6:    reg_rdata = {15'b0, rf_q, 7'b0, tf_q, 8'b0};
      default: reg_rdata = '0;
    endcase

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_stat) |-> (stat_q & $past(stat_q)) == $past(stat_q)); // R9
  AST_HIT_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    bp_trap |=> stat_q[$past(bp_slot)]); // R8
  AST_STEP_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    step_trap |=> stat_q[4]); // R11
  AST_RF_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    insn_done && !wr_flags |=> !rf_q); // R10
  AST_IO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & io_kind) == '0); // R6
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    bp_trap |-> ctrl_q[2*bp_slot]); // R7
endmodule

// File: tb/hw_brk_unit_tb.sv
`timescale 1ns/1ps
module hw_brk_unit_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        fetch_valid = 0, insn_done = 0, data_valid = 0, data_write = 0;
  logic [31:0] fetch_addr = 0, data_addr = 0;
  logic [1:0]  data_size = 0, bp_slot;
  logic        bp_trap, step_trap;
  int vecs = 0, bad = 0;

  always #10 clk = ~clk;

  hw_brk_unit #(.AW(32)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input logic [2:0] s, output logic [31:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic dacc(input logic [31:0] a, input logic [1:0] sz, input logic w,
                      output logic t, output logic [1:0] sl);
    @(negedge clk); data_valid = 1; data_addr = a; data_size = sz; data_write = w;
    #2; t = bp_trap; sl = bp_slot;
    @(negedge clk); data_valid = 0;
  endtask

  task automatic fetch(input logic [31:0] a, output logic t, output logic [1:0] sl);
    @(negedge clk); fetch_valid = 1; fetch_addr = a;
    #2; t = bp_trap; sl = bp_slot;
    @(negedge clk); fetch_valid = 0;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic t;
    logic [1:0] sl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 7; s++) begin
      rreg(3'(s), r); check("R1 reset regs", r, 0);
    end
    check("R1 no trap", {bp_trap, step_trap}, 0);

    // R2 address registers
    for (int s = 0; s < 4; s++) wreg(3'(s), 32'hA500_0000 + s * 16);
    for (int s = 0; s < 4; s++) begin
      rreg(3'(s), r); check("R2 addr readback", r, 32'hA500_0000 + s * 16);
    end

    // R5 sweep: slot 1 data rw at 0x10000040, every length and size
    wreg(3'd1, 32'h1000_0040);
    for (int c = 0; c < 4; c++) begin
      int L;
      L = (c == 0) ? 1 : (c == 1) ? 2 : (c == 3) ? 4 : 8;
      wreg(3'd4, (1 << 2) | (3 << 20) | (c << 22));
      for (int s = 0; s < 4; s++) begin
        int S;
        S = 1 << s;
        for (int a = 'h30; a < 'h58; a += S) begin
          logic ex;
          ex = (a < 'h40 + L) && ('h40 < a + S);
          dacc(32'h1000_0000 + a, 2'(s), 1'(a & 1), t, sl);
          check("R5 overlap", t, ex);
          if (ex) check("R5 slot", sl, 1);
        end
      end
    end
    rreg(3'd5, r); check("R9 sticky slot1", r, 32'h2);
    wreg(3'd5, 32'hFFFF_FFFF);
    rreg(3'd5, r); check("R9 write mask", r, 32'h400F);
    wreg(3'd5, 0);
    rreg(3'd5, r); check("R9 clear", r, 0);

    // R3 / R4 instruction slot 2 with bogus length
    wreg(3'd2, 32'h2000);
    wreg(3'd4, (1 << 4) | (3 << 26));
    rreg(3'd4, r); check("R3 insn length forced", r, 32'h10);
    for (int a = 'h1FFC; a <= 'h2004; a++) begin
      fetch(a, t, sl);
      check("R4 exact fetch", t, a == 'h2000);
      if (a == 'h2000) check("R4 slot", sl, 2);
    end
    rreg(3'd5, r); check("R4 status", r, 32'h4);
    wreg(3'd5, 0);

    // R10 resume flag
    wreg(3'd4, (1 << 4) | (1 << 2) | (3 << 20) | (3 << 22));
    wreg(3'd6, 1 << 16);
    fetch(32'h2000, t, sl); check("R10 fetch hidden", t, 0);
    fetch(32'h2000, t, sl); check("R10 still hidden", t, 0);
    dacc(32'h1000_0041, 0, 0, t, sl); check("R10 data unaffected", {t, sl}, 3'b101);
    rreg(3'd6, r); check("R10 flag held", r, 32'h1_0000);
    @(negedge clk); insn_done = 1; @(negedge clk); insn_done = 0;
    rreg(3'd6, r); check("R10 flag cleared", r, 0);
    fetch(32'h2000, t, sl); check("R10 fetch after clear", {t, sl}, 3'b110);
    wreg(3'd5, 0);

    // R11 trap flag
    wreg(3'd6, 1 << 8);
    @(negedge clk); insn_done = 1; #2; check("R11 step trap", step_trap, 1);
    @(negedge clk); insn_done = 0; #2; check("R11 step low", step_trap, 0);
    rreg(3'd5, r); check("R11 status bit14", r, 32'h4000);
    repeat (3) @(negedge clk);
    rreg(3'd5, r); check("R9 step sticky", r, 32'h4000);
    wreg(3'd6, 0);
    wreg(3'd5, 0);

    // R8 priority, slots 0 and 3 on the same word
    wreg(3'd0, 32'h3000);
    wreg(3'd3, 32'h3000);
    wreg(3'd4, 1 | (1 << 6) | (3 << 16) | (3 << 18) | (3 << 28) | (3 << 30));
    dacc(32'h3002, 0, 0, t, sl); check("R8 lowest slot", {t, sl}, 3'b100);
    rreg(3'd5, r); check("R8 both status", r, 32'h9);
    wreg(3'd5, 0);

    // R7 disable keeps fields
    wreg(3'd4, (1 << 6) | (3 << 16) | (3 << 18) | (3 << 28) | (3 << 30));
    rreg(3'd4, r); check("R7 fields intact", r, (1 << 6) | (3 << 16) | (3 << 18) | (3 << 28) | (3 << 30));
    dacc(32'h3002, 0, 0, t, sl); check("R7 slot3 only", {t, sl}, 3'b111);
    wreg(3'd4, (3 << 16) | (3 << 18) | (3 << 28) | (3 << 30));
    dacc(32'h3002, 0, 1, t, sl); check("R7 all disabled", t, 0);
    rreg(3'd0, r); check("R7 address intact", r, 32'h3000);
    wreg(3'd5, 0);
    rreg(3'd5, r); check("R7 status after disable", r, 0);

    // R6 kinds
    wreg(3'd4, 1 | (1 << 16) | (3 << 18));
    dacc(32'h3000, 2, 0, t, sl); check("R6 write-only ignores read", t, 0);
    dacc(32'h3000, 2, 1, t, sl); check("R6 write-only write", {t, sl}, 3'b100);
    wreg(3'd4, 1 | (2 << 16) | (3 << 18));
    wreg(3'd5, 0);
    dacc(32'h3000, 2, 0, t, sl); check("R6 io read silent", t, 0);
    dacc(32'h3000, 2, 1, t, sl); check("R6 io write silent", t, 0);
    fetch(32'h3000, t, sl); check("R6 io fetch silent", t, 0);
    rreg(3'd5, r); check("R6 io status", r, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule